// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block sets the pace for an asynchronous serial port. It issues two single-cycle enable pulses in the system clock domain. The first is an oversampling tick at sixteen times the bit rate. The second is a bit tick that marks every sixteenth oversampling tick. The serial shifter downstream uses both pulses as clock enables. Neither pulse stalls or waits for a consumer, so the block has no data stream and no back-pressure. Every pin is a plain control or status signal.

There are two ways to set the rate. In variable mode, the oversampling tick is the overflow pulse of one auto-reload timer. That timer is either an 8-bit counter or one of several 16-bit counters. All timers run side by side and advance only on cycles where the timer clock enable is high. When a timer wraps, it reloads from its reload input on the same edge, so no count is lost. In fixed mode, the timers are bypassed and the system clock is divided directly. A rate-doubling input picks between a bit rate of the system clock divided by 64 and divided by 32.

Top module: `brg_baud_gen`

## Requirements
- R1: While reset is asserted, both tick outputs are low. Reset clears every counter and the divide-by-16 prescaler, so the first bit tick after reset comes with the 16th oversampling tick.
- R2: With fixed_mode=0 and src_sel=0, the oversampling tick period is (256 − reload8) timer-clock-enabled cycles.
- R3: With fixed_mode=0 and src_sel=k (k = 1..3), the oversampling tick period is (65536 − R) enabled cycles. R is the 16-bit slice reload16[16k−1:16(k−1)]. The other slices have no effect on the output.
- R4: A timer advances only on cycles where tmr_clk_en is high. Holding the enable low on every other cycle doubles the period in clocks.
- R5: With fixed_mode=1, the oversampling tick period is 4 system clocks when rate_dbl=0 and 2 when rate_dbl=1. The bit rate is therefore the system clock divided by 64 or by 32. tmr_clk_en has no effect in this mode.
- R6: bit_tick is high only together with os_tick, on every 16th os_tick. Its period is 16 times the os_tick period.
- R7: A new reload value takes effect at the next overflow. Changing it does not restart the running count.
- R8: rate_dbl has no effect when fixed_mode=0.
- R9: bit_tick is never high on two consecutive cycles. In fixed mode, os_tick is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk_en | input | 1 | Timer clock enable; stands in for the timer prescaler |
| fixed_mode | input | 1 | 1 = fixed system-clock divide, 0 = timer overflow |
| rate_dbl | input | 1 | In fixed mode: 1 = divide by 32, 0 = divide by 64 |
| src_sel | input | 2 | 0 = 8-bit timer; k = 16-bit timer k (1..3) |
| reload8 | input | 8 | Reload value of the 8-bit timer |
| reload16 | input | 48 | Reload values of the 16-bit timers, 16 bits each, timer 1 in the low slice |
| os_tick | output | 1 | 16x oversampling pulse, one cycle wide |
| bit_tick | output | 1 | Bit-rate pulse, one cycle wide |

## Verification
On every cycle, assertions check several properties. A timer holds its count when the enable is low. An overflow leaves the counter at the reload value from the edge before. The prescaler steps only on an oversampling tick and wraps modulo 16. The fixed divider and the bit tick never pulse on back-to-back cycles. Some behaviours are visible only in the bench scenarios, where tick periods are measured and compared: the exact period for each reload value and source selection, the doubled period under a gated enable, the delayed effect of a reload change, and the position of the first bit tick after reset.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Oversampling ratio between the sampling tick and the bit tick.
  localparam int unsigned OS_RATIO    = 16;
  // Fixed-mode bit-rate divisors of the system clock.
  localparam int unsigned FIX_DIV_STD = 64;
  localparam int unsigned FIX_DIV_DBL = 32;
  // Derived oversampling periods in system clocks.
  localparam int unsigned FIX_OS_STD  = FIX_DIV_STD / OS_RATIO;
  localparam int unsigned FIX_OS_DBL  = FIX_DIV_DBL / OS_RATIO;
endpackage

// File: rtl/brg_reload_timer.sv
module brg_reload_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (en) begin
      if (cnt == TOP) begin
        cnt <= reload;
        ovf <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        ovf <= 1'b0;
      end
    end else begin
      ovf <= 1'b0;
    end
  end

  // R4: a timer without its enable keeps its count
  assert_hold_no_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(cnt));

  // R7: an overflow leaves the counter at the reload value sampled on that edge
  assert_reload_on_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == $past(reload));
endmodule

// File: rtl/brg_fixed_div.sv
module brg_fixed_div
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  output logic tick
);
  localparam int unsigned CW = (FIX_OS_STD > 1) ? $clog2(FIX_OS_STD) : 1;
  localparam logic [CW-1:0] LIM_STD = CW'(FIX_OS_STD - 1);
  localparam logic [CW-1:0] LIM_DBL = CW'(FIX_OS_DBL - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = dbl ? LIM_DBL : LIM_STD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R9: the fixed divider never pulses on two adjacent cycles
  assert_fixed_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/brg_os_prescaler.sv
module brg_os_prescaler
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  output logic bit_tick
);
  localparam int unsigned PW = $clog2(OS_RATIO);
  localparam logic [PW-1:0] LAST = PW'(OS_RATIO - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (os_tick) pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  assign bit_tick = os_tick && (pre == LAST);

  // R6: the prescaler steps once per oversampling tick and wraps after OS_RATIO steps
  assert_pre_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> pre == ((($past(pre)) == LAST) ? '0 : PW'($past(pre) + 1'b1)));
  assert_pre_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !os_tick |=> $stable(pre));
endmodule

// File: rtl/brg_baud_gen.sv
module brg_baud_gen #(
  parameter int unsigned NUM_T16 = 3,
  parameter int unsigned W8      = 8,
  parameter int unsigned W16     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tmr_clk_en,
  input  logic                     fixed_mode,
  input  logic                     rate_dbl,
  input  logic [$clog2(NUM_T16+1)-1:0] src_sel,
  input  logic [W8-1:0]            reload8,
  input  logic [NUM_T16*W16-1:0]   reload16,
  output logic                     os_tick,
  output logic                     bit_tick
);
  localparam int unsigned SEL_W = $clog2(NUM_T16 + 1);

  logic               ovf8;
  logic [NUM_T16-1:0] ovf16;
  logic               fix_tick;
  logic               var_tick;

  brg_reload_timer #(.W(W8)) u_t8 (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tmr_clk_en),
    .reload (reload8),
    .ovf    (ovf8)
  );

  for (genvar g = 0; g < NUM_T16; g++) begin : g_t16
    brg_reload_timer #(.W(W16)) u_t16 (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (tmr_clk_en),
      .reload (reload16[g*W16 +: W16]),
      .ovf    (ovf16[g])
    );
  end

  brg_fixed_div u_fix (
    .clk   (clk),
    .rst_n (rst_n),
    .dbl   (rate_dbl),
    .tick  (fix_tick)
  );

  always_comb begin
    var_tick = ovf8;
    for (int k = 0; k < NUM_T16; k++) begin
      if (src_sel == SEL_W'(k + 1)) var_tick = ovf16[k];
    end
  end

  assign os_tick = fixed_mode ? fix_tick : var_tick;

  brg_os_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

  // R9: bit ticks are isolated single-cycle pulses
  assert_bit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R1: outputs quiet during reset
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!bit_tick);
  end
endmodule

// File: tb/brg_baud_gen_tb.sv
module brg_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_clk_en = 1'b1;
  logic        fixed_mode = 1'b0;
  logic        rate_dbl = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [7:0]  reload8 = '0;
  logic [47:0] reload16 = '0;
  logic        os_tick;
  logic        bit_tick;

  int n_chk = 0;
  int n_bad = 0;
  int en_div = 1;

  always #4 clk = ~clk;

  brg_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_clk_en(tmr_clk_en), .fixed_mode(fixed_mode),
    .rate_dbl(rate_dbl), .src_sel(src_sel), .reload8(reload8), .reload16(reload16),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  always @(negedge clk) tmr_clk_en <= (en_div == 1) ? 1'b1 : ~tmr_clk_en;

  typedef struct packed {
    logic        fx;
    logic        db;
    logic [1:0]  sel;
    logic [7:0]  r8;
    logic [15:0] r16;
    logic [1:0]  ediv;
    logic [15:0] exp_os;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 8'd0,   16'h0000, 2'd1, 16'd4},   // R5 std
    '{1'b1, 1'b1, 2'd0, 8'd0,   16'h0000, 2'd1, 16'd2},   // R5 doubled
    '{1'b1, 1'b0, 2'd0, 8'd0,   16'h0000, 2'd2, 16'd4},   // R5 enable ignored
    '{1'b0, 1'b0, 2'd0, 8'd240, 16'h0000, 2'd1, 16'd16},  // R2
    '{1'b0, 1'b1, 2'd0, 8'd250, 16'h0000, 2'd1, 16'd6},   // R8
    '{1'b0, 1'b0, 2'd0, 8'd246, 16'h0000, 2'd2, 16'd20},  // R4
    '{1'b0, 1'b0, 2'd0, 8'd255, 16'h0000, 2'd1, 16'd1},   // R2 minimum
    '{1'b0, 1'b0, 2'd1, 8'd0,   16'hFFF0, 2'd1, 16'd16},  // R3 timer 1
    '{1'b0, 1'b0, 2'd2, 8'd0,   16'hFFE0, 2'd1, 16'd32},  // R3 timer 2
    '{1'b0, 1'b0, 2'd3, 8'd0,   16'hFFFA, 2'd1, 16'd6},   // R3 timer 3
    '{1'b0, 1'b0, 2'd3, 8'd0,   16'hFFF8, 2'd2, 16'd16}   // R4 16-bit
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_os();
    do @(negedge clk); while (!os_tick);
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!bit_tick);
  endtask

  task automatic period_os(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!os_tick);
  endtask

  task automatic period_bit(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!bit_tick);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p;
    int cnt;
    int seen;

    // R1: reset state and cleared prescaler (fixed, doubled)
    fixed_mode = 1'b1; rate_dbl = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 os_tick in reset", int'(os_tick), 0);
    check("R1 bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    cnt = 0;
    do begin @(negedge clk); if (os_tick) cnt++; end while (!bit_tick);
    check("R1 os ticks up to first bit tick", cnt, 16);

    // R9: no back-to-back oversampling pulses in fixed mode
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      p = int'(os_tick);
      @(negedge clk);
      if (p == 1 && os_tick) seen++;
    end
    check("R9 adjacent os pulses", seen, 0);

    // R1: first 8-bit overflow after reset needs 256 counts
    rst_n = 1'b0; fixed_mode = 1'b0; src_sel = 2'd0; reload8 = 8'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (os_tick) seen++; end
    check("R1 no early overflow", seen, 0);

    // R7: reload change waits for the next overflow
    wait_os();
    reload8 = 8'd200;
    period_os(p);
    check("R7 old count kept", p, 256);
    period_os(p);
    check("R7 new reload used", p, 56);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      fixed_mode = VECS[v].fx;
      rate_dbl   = VECS[v].db;
      src_sel    = VECS[v].sel;
      reload8    = VECS[v].r8;
      reload16   = {16'hFF00, 16'hFF00, 16'hFF00};
      if (VECS[v].sel != 2'd0) reload16[(int'(VECS[v].sel)-1)*16 +: 16] = VECS[v].r16;
      en_div     = int'(VECS[v].ediv);
      wait_os();
      wait_os();
      period_os(p);
      check($sformatf("R2/R3/R4/R5/R8 os period vec %0d", v), p, int'(VECS[v].exp_os));
      wait_bit();
      period_bit(p);
      check($sformatf("R6 bit period vec %0d", v), p, 16 * int'(VECS[v].exp_os));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule